// File: doc/BRIEF.md
# Trap Entry Sequencer

This block is the trap-entry control for a small 32-bit soft processor. Each cycle it looks at the pending events: hardware exception, MMU fault, hardware break, software break and external interrupt. It decides which one, if any, may be taken. For the winning event it issues a single registered redirect. The redirect carries the new program counter, an optional link-register write (index and value), and new values for the machine-status word and the exception-status, exception-address and branch-target registers, each with its own write strobe.

The pipeline supplies the current PC, the delay-slot and immediate-prefix flags, the pending branch target and the current machine-status word. It applies the returned values on the redirect strobe. A `flags_clr` strobe tells the pipeline to drop its delay-slot and immediate-prefix flags. A sticky `dbl_fault` output reports a recursive MMU fault.

Top module: `trap_entry_seq`

## Requirements
- R1: A hardware exception with `exc_unit_en` high redirects to BASE+0x20. It writes PC+4 to link register 17. It writes an exception status whose bits [4:0] are `exc_cause` and whose bit 12 equals `in_dslot`, with all other bits zero.
- R2: An MMU fault redirects to BASE+0x20, writes the faulting PC to link register 17, and writes `mmu_addr` into the exception-address register. The exception-status code in bits [4:0] is set as follows. A miss (`mmu_is_miss`=1) gives 18 for a data access and 19 for a fetch (`mmu_is_fetch`=1). A protection fault gives 16 for data and 17 for a fetch. Bit 10 is set for a store (`mmu_is_store`=1), and bit 12 equals `in_dslot`.
- R3: An accepted interrupt redirects to BASE+0x10 and writes the PC to link register 14. It sets neither the exception-in-progress bit nor the break-in-progress bit, and it does not write the exception-status register.
- R4: An interrupt is accepted only when all of the following hold: status bit 1 (interrupt enable) is 1, status bit 9 (exception in progress) is 0, status bit 3 (break in progress) is 0, `in_dslot` is 0 and `imm_prefix` is 0. Otherwise no redirect occurs.
- R5: A hardware break redirects to BASE+0x18 and writes the PC to link register 16. A software break redirects to `branch_target` without a link write. Both set status bit 3.
- R6: On every entry, status bit 11 (user mode) is copied to bit 12 and bit 13 (virtual mode) is copied to bit 14. The previous bits 12 and 14 are discarded, bits 11 and 13 become 0, and all other status bits pass through unchanged.
- R7: Hardware-exception and MMU-fault entries set status bit 9 and pulse `flags_clr`. Interrupt and break entries do not pulse `flags_clr`.
- R8: A hardware-exception or MMU-fault entry with `in_dslot` high writes `branch_target` to the branch-target register (`btr_we`=1). Without a delay slot, `btr_we` stays 0.
- R9: With `exc_unit_en` low, a hardware exception is ignored. A lower-priority event pending in the same cycle is taken instead.
- R10: Priority is MMU fault, then hardware exception, then hardware break, then software break, then interrupt. At most one redirect is issued per cycle.
- R11: An MMU fault that arrives while status bit 9 is already set causes no redirect in that cycle. It sets `dbl_fault`, which stays high until reset.
- R12: All outputs are registered. The redirect appears in the cycle after the request is sampled, and `rdr_valid` is high for exactly one cycle per sampled event. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction at which the event is taken |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| imm_prefix | input | 1 | Instruction follows an immediate prefix |
| branch_target | input | 32 | Pending branch target |
| msr_in | input | 32 | Current machine-status word |
| exc_unit_en | input | 1 | Hardware exceptions configured on |
| hwexc_req | input | 1 | Hardware exception pending |
| exc_cause | input | 5 | Hardware exception cause code |
| mmu_req | input | 1 | MMU fault pending |
| mmu_addr | input | 32 | Faulting address |
| mmu_is_miss | input | 1 | 1 = translation miss, 0 = protection fault |
| mmu_is_fetch | input | 1 | Fault on an instruction fetch |
| mmu_is_store | input | 1 | Fault on a store |
| hwbrk_req | input | 1 | Hardware break pending |
| swbrk_req | input | 1 | Software break pending |
| irq_req | input | 1 | External interrupt pending |
| rdr_valid | output | 1 | One-cycle redirect strobe |
| rdr_pc | output | 32 | New program counter |
| link_we | output | 1 | Link-register write enable |
| link_idx | output | 5 | Link-register index |
| link_data | output | 32 | Link-register value |
| msr_out | output | 32 | New machine-status word |
| esr_we | output | 1 | Exception-status write enable |
| esr_out | output | 32 | New exception status |
| ear_we | output | 1 | Exception-address write enable |
| ear_out | output | 32 | New exception address |
| btr_we | output | 1 | Branch-target register write enable |
| btr_out | output | 32 | New branch-target register value |
| flags_clr | output | 1 | Clear delay-slot and immediate-prefix flags |
| dbl_fault | output | 1 | Sticky recursive-fault error |

## Verification
The only state the block keeps is its output registers and the sticky error bit. A wrong arbitration or gating decision therefore shows one cycle after the request, as a missing, extra or misdirected redirect: a wrong vector, a wrong link index or a status word with the wrong progress bit. A fault in the mode-save logic shows in the same cycle in `msr_out`, as stale save bits or live mode bits left set. A broken sticky flag shows as `dbl_fault` dropping on the first cycle after the double fault clears.

// File: rtl/trap_seq_pkg.sv
// Package: shared event encoding and bit positions for the trap-entry logic.
// Assumes a 32-bit status word with the bit map listed below.
package trap_seq_pkg;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_HWEXC = 3'd1,
        EV_MMU   = 3'd2,
        EV_HWBRK = 3'd3,
        EV_SWBRK = 3'd4,
        EV_IRQ   = 3'd5
    } trap_ev_e;

    // Machine-status bit positions
    localparam int MSR_IE  = 1;
    localparam int MSR_BIP = 3;
    localparam int MSR_EIP = 9;
    localparam int MSR_UM  = 11;
    localparam int MSR_UMS = 12;
    localparam int MSR_VM  = 13;
    localparam int MSR_VMS = 14;

    // Exception-status bit positions and MMU codes
    localparam int ESR_STORE = 10;
    localparam int ESR_DSLOT = 12;
    localparam int CODE_W    = 5;
    localparam logic [CODE_W-1:0] CODE_PROT_DATA  = 5'd16;
    localparam logic [CODE_W-1:0] CODE_PROT_FETCH = 5'd17;
    localparam logic [CODE_W-1:0] CODE_MISS_DATA  = 5'd18;
    localparam logic [CODE_W-1:0] CODE_MISS_FETCH = 5'd19;

    // Link register indices
    localparam int REG_IDX_W = 5;
    localparam logic [REG_IDX_W-1:0] LINK_EXC = 5'd17;
    localparam logic [REG_IDX_W-1:0] LINK_BRK = 5'd16;
    localparam logic [REG_IDX_W-1:0] LINK_IRQ = 5'd14;

    // Vector offsets from the base
    localparam int OFS_IRQ = 'h10;
    localparam int OFS_BRK = 'h18;
    localparam int OFS_EXC = 'h20;

endpackage

// File: rtl/trap_arbiter.sv
// Module: picks the single event to take this cycle and flags recursive MMU faults.
// Assumes requests are level signals sampled every cycle; purely combinational.
module trap_arbiter
    import trap_seq_pkg::*;
(
    input  logic     hwexc_req,
    input  logic     mmu_req,
    input  logic     hwbrk_req,
    input  logic     swbrk_req,
    input  logic     irq_req,
    input  logic     exc_unit_en,
    input  logic     in_dslot,
    input  logic     imm_prefix,
    input  logic     st_ie,
    input  logic     st_eip,
    input  logic     st_bip,
    output trap_ev_e ev,
    output logic     dbl_hit
);

    logic irq_ok;
    logic hwexc_ok;

    // Gate each request by its acceptance condition.
    always_comb begin
        irq_ok   = irq_req & st_ie & ~st_eip & ~st_bip & ~in_dslot & ~imm_prefix;
        hwexc_ok = hwexc_req & exc_unit_en;
        dbl_hit  = mmu_req & st_eip;
    end

    // Fixed-priority selection, one winner at most.
    always_comb begin
        ev = EV_NONE;
        if (dbl_hit)        ev = EV_NONE;
        else if (mmu_req)   ev = EV_MMU;
        else if (hwexc_ok)  ev = EV_HWEXC;
        else if (hwbrk_req) ev = EV_HWBRK;
        else if (swbrk_req) ev = EV_SWBRK;
        else if (irq_ok)    ev = EV_IRQ;
    end

endmodule

// File: rtl/trap_status.sv
// Module: computes the new status word and exception-status value for an entry.
// Assumes the status bit map from trap_seq_pkg; purely combinational.
module trap_status
    import trap_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trap_ev_e            ev,
    input  logic [XLEN-1:0]     msr_in,
    input  logic                in_dslot,
    input  logic                mmu_is_miss,
    input  logic                mmu_is_fetch,
    input  logic                mmu_is_store,
    input  logic [CODE_W-1:0]   exc_cause,
    output logic [XLEN-1:0]     msr_next,
    output logic [XLEN-1:0]     esr_next,
    output logic                esr_we,
    output logic                ear_we,
    output logic                btr_we,
    output logic                flags_clr
);

    logic              is_exc;
    logic              is_brk;
    logic [XLEN-1:0]   mode_saved;
    logic [CODE_W-1:0] mmu_code;

    // Classify the event into exception-like and break-like entries.
    always_comb begin
        is_exc = (ev == EV_HWEXC) || (ev == EV_MMU);
        is_brk = (ev == EV_HWBRK) || (ev == EV_SWBRK);
    end

    // Save mode bits one position up, clear live and old saved copies, set progress bits.
    always_comb begin
        mode_saved           = '0;
        mode_saved[MSR_UMS]  = msr_in[MSR_UM];
        mode_saved[MSR_VMS]  = msr_in[MSR_VM];
        msr_next             = msr_in;
        msr_next[MSR_UM]     = 1'b0;
        msr_next[MSR_UMS]    = 1'b0;
        msr_next[MSR_VM]     = 1'b0;
        msr_next[MSR_VMS]    = 1'b0;
        msr_next             = msr_next | mode_saved;
        if (is_exc) msr_next[MSR_EIP] = 1'b1;
        if (is_brk) msr_next[MSR_BIP] = 1'b1;
    end

    // Select the MMU fault code from miss/protection and fetch/data.
    always_comb begin
        if (mmu_is_miss) mmu_code = mmu_is_fetch ? CODE_MISS_FETCH : CODE_MISS_DATA;
        else             mmu_code = mmu_is_fetch ? CODE_PROT_FETCH : CODE_PROT_DATA;
    end

    // Assemble the exception-status word and the register write strobes.
    always_comb begin
        esr_next = '0;
        if (ev == EV_MMU) begin
            esr_next[CODE_W-1:0] = mmu_code;
            esr_next[ESR_STORE]  = mmu_is_store;
        end else begin
            esr_next[CODE_W-1:0] = exc_cause;
        end
        esr_next[ESR_DSLOT] = in_dslot;
        esr_we    = is_exc;
        ear_we    = (ev == EV_MMU);
        btr_we    = is_exc & in_dslot;
        flags_clr = is_exc;
    end

endmodule

// File: rtl/trap_vector.sv
// Module: computes the redirect target and link-register write for the chosen event.
// Assumes a fixed vector base; purely combinational.
module trap_vector
    import trap_seq_pkg::*;
#(
    parameter int              XLEN = 32,
    parameter logic [XLEN-1:0] BASE = '0
) (
    input  trap_ev_e               ev,
    input  logic [XLEN-1:0]        cur_pc,
    input  logic [XLEN-1:0]        branch_target,
    output logic [XLEN-1:0]        pc_next,
    output logic                   link_we,
    output logic [REG_IDX_W-1:0]   link_idx,
    output logic [XLEN-1:0]        link_data
);

    localparam logic [XLEN-1:0] VEC_EXC = BASE + XLEN'(OFS_EXC);
    localparam logic [XLEN-1:0] VEC_BRK = BASE + XLEN'(OFS_BRK);
    localparam logic [XLEN-1:0] VEC_IRQ = BASE + XLEN'(OFS_IRQ);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    // Map each event class onto its vector, link register and link value.
    always_comb begin
        pc_next   = '0;
        link_we   = 1'b0;
        link_idx  = '0;
        link_data = '0;
        case (ev)
            EV_HWEXC: begin
                pc_next   = VEC_EXC;
                link_we   = 1'b1;
                link_idx  = LINK_EXC;
                link_data = cur_pc + INSN_BYTES;
            end
            EV_MMU: begin
                pc_next   = VEC_EXC;
                link_we   = 1'b1;
                link_idx  = LINK_EXC;
                link_data = cur_pc;
            end
            EV_HWBRK: begin
                pc_next   = VEC_BRK;
                link_we   = 1'b1;
                link_idx  = LINK_BRK;
                link_data = cur_pc;
            end
            EV_SWBRK: begin
                pc_next   = branch_target;
            end
            EV_IRQ: begin
                pc_next   = VEC_IRQ;
                link_we   = 1'b1;
                link_idx  = LINK_IRQ;
                link_data = cur_pc;
            end
            default: begin
                pc_next   = '0;
            end
        endcase
    end

endmodule

// File: rtl/trap_entry_seq.sv
// Module: top of the trap-entry sequencer; registers the chosen redirect and
// all register updates, and holds the sticky double-fault flag.
// Assumes the pipeline applies the outputs on rdr_valid and drops requests once served.
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int              XLEN = 32,
    parameter logic [XLEN-1:0] BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic                 in_dslot,
    input  logic                 imm_prefix,
    input  logic [XLEN-1:0]      branch_target,
    input  logic [XLEN-1:0]      msr_in,
    input  logic                 exc_unit_en,
    input  logic                 hwexc_req,
    input  logic [CODE_W-1:0]    exc_cause,
    input  logic                 mmu_req,
    input  logic [XLEN-1:0]      mmu_addr,
    input  logic                 mmu_is_miss,
    input  logic                 mmu_is_fetch,
    input  logic                 mmu_is_store,
    input  logic                 hwbrk_req,
    input  logic                 swbrk_req,
    input  logic                 irq_req,
    output logic                 rdr_valid,
    output logic [XLEN-1:0]      rdr_pc,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_data,
    output logic [XLEN-1:0]      msr_out,
    output logic                 esr_we,
    output logic [XLEN-1:0]      esr_out,
    output logic                 ear_we,
    output logic [XLEN-1:0]      ear_out,
    output logic                 btr_we,
    output logic [XLEN-1:0]      btr_out,
    output logic                 flags_clr,
    output logic                 dbl_fault
);

    localparam logic [XLEN-1:0] VEC_IRQ = BASE + XLEN'(OFS_IRQ);

    trap_ev_e               ev;
    logic                   dbl_hit;
    logic                   take;
    logic [XLEN-1:0]        pc_c;
    logic                   link_we_c;
    logic [REG_IDX_W-1:0]   link_idx_c;
    logic [XLEN-1:0]        link_data_c;
    logic [XLEN-1:0]        msr_c;
    logic [XLEN-1:0]        esr_c;
    logic                   esr_we_c;
    logic                   ear_we_c;
    logic                   btr_we_c;
    logic                   flags_clr_c;

    trap_arbiter arb_i (
        .hwexc_req   (hwexc_req),
        .mmu_req     (mmu_req),
        .hwbrk_req   (hwbrk_req),
        .swbrk_req   (swbrk_req),
        .irq_req     (irq_req),
        .exc_unit_en (exc_unit_en),
        .in_dslot    (in_dslot),
        .imm_prefix  (imm_prefix),
        .st_ie       (msr_in[MSR_IE]),
        .st_eip      (msr_in[MSR_EIP]),
        .st_bip      (msr_in[MSR_BIP]),
        .ev          (ev),
        .dbl_hit     (dbl_hit)
    );

    trap_status #(.XLEN(XLEN)) status_i (
        .ev           (ev),
        .msr_in       (msr_in),
        .in_dslot     (in_dslot),
        .mmu_is_miss  (mmu_is_miss),
        .mmu_is_fetch (mmu_is_fetch),
        .mmu_is_store (mmu_is_store),
        .exc_cause    (exc_cause),
        .msr_next     (msr_c),
        .esr_next     (esr_c),
        .esr_we       (esr_we_c),
        .ear_we       (ear_we_c),
        .btr_we       (btr_we_c),
        .flags_clr    (flags_clr_c)
    );

    trap_vector #(.XLEN(XLEN), .BASE(BASE)) vector_i (
        .ev            (ev),
        .cur_pc        (cur_pc),
        .branch_target (branch_target),
        .pc_next       (pc_c),
        .link_we       (link_we_c),
        .link_idx      (link_idx_c),
        .link_data     (link_data_c)
    );

    // A redirect is issued whenever the arbiter picked an event.
    always_comb take = (ev != EV_NONE);

    // Register strobes each cycle so that every strobe lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_valid <= 1'b0;
            link_we   <= 1'b0;
            esr_we    <= 1'b0;
            ear_we    <= 1'b0;
            btr_we    <= 1'b0;
            flags_clr <= 1'b0;
        end else begin
            rdr_valid <= take;
            link_we   <= link_we_c;
            esr_we    <= esr_we_c;
            ear_we    <= ear_we_c;
            btr_we    <= btr_we_c;
            flags_clr <= flags_clr_c;
        end
    end

    // Capture redirect data and register values only when an event is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_pc    <= '0;
            link_idx  <= '0;
            link_data <= '0;
            msr_out   <= '0;
            esr_out   <= '0;
            ear_out   <= '0;
            btr_out   <= '0;
        end else if (take) begin
            rdr_pc    <= pc_c;
            link_idx  <= link_idx_c;
            link_data <= link_data_c;
            msr_out   <= msr_c;
            if (esr_we_c) esr_out <= esr_c;
            if (ear_we_c) ear_out <= mmu_addr;
            if (btr_we_c) btr_out <= branch_target;
        end
    end

    // Sticky recursive-fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) dbl_fault <= 1'b0;
        else        dbl_fault <= dbl_fault | dbl_hit;
    end

    // R6
    mode_off_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_valid |-> (!msr_out[MSR_UM] && !msr_out[MSR_VM]));

    // R12
    link_needs_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> rdr_valid);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_valid && link_we && link_idx == LINK_IRQ && rdr_pc == VEC_IRQ) |->
        ($past(msr_in[MSR_IE]) && !$past(msr_in[MSR_EIP]) && !$past(msr_in[MSR_BIP])
         && !$past(in_dslot) && !$past(imm_prefix)));

    // R11
    dbl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_fault |=> dbl_fault);

    // R11
    dbl_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbl_fault) |-> !rdr_valid);

    // R7
    flags_clr_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_clr |-> (rdr_valid && msr_out[MSR_EIP] && esr_we));

    // R2
    ear_with_esr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ear_we |-> (esr_we && link_idx == LINK_EXC));

    // R10
    one_progress_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_valid |-> !(esr_we && !msr_out[MSR_EIP]));

endmodule

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h8000_0000;

    localparam int B_IE = 1, B_BIP = 3, B_EIP = 9, B_UM = 11, B_UMS = 12, B_VM = 13, B_VMS = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cur_pc, branch_target, msr_in, mmu_addr;
    logic        in_dslot, imm_prefix, exc_unit_en;
    logic        hwexc_req, mmu_req, hwbrk_req, swbrk_req, irq_req;
    logic [4:0]  exc_cause;
    logic        mmu_is_miss, mmu_is_fetch, mmu_is_store;
    logic        rdr_valid, link_we, esr_we, ear_we, btr_we, flags_clr, dbl_fault;
    logic [31:0] rdr_pc, link_data, msr_out, esr_out, ear_out, btr_out;
    logic [4:0]  link_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    trap_entry_seq #(.XLEN(32), .BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .in_dslot(in_dslot),
        .imm_prefix(imm_prefix), .branch_target(branch_target), .msr_in(msr_in),
        .exc_unit_en(exc_unit_en), .hwexc_req(hwexc_req), .exc_cause(exc_cause),
        .mmu_req(mmu_req), .mmu_addr(mmu_addr), .mmu_is_miss(mmu_is_miss),
        .mmu_is_fetch(mmu_is_fetch), .mmu_is_store(mmu_is_store),
        .hwbrk_req(hwbrk_req), .swbrk_req(swbrk_req), .irq_req(irq_req),
        .rdr_valid(rdr_valid), .rdr_pc(rdr_pc), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data), .msr_out(msr_out),
        .esr_we(esr_we), .esr_out(esr_out), .ear_we(ear_we), .ear_out(ear_out),
        .btr_we(btr_we), .btr_out(btr_out), .flags_clr(flags_clr),
        .dbl_fault(dbl_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected status word after entry, from the mode-save rule.
    function automatic logic [31:0] exp_msr(input logic [31:0] m, input bit eip, input bit bip);
        logic [31:0] r;
        r = m;
        r[B_UM] = 1'b0; r[B_VM] = 1'b0;
        r[B_UMS] = m[B_UM]; r[B_VMS] = m[B_VM];
        if (eip) r[B_EIP] = 1'b1;
        if (bip) r[B_BIP] = 1'b1;
        return r;
    endfunction

    task automatic clear_reqs();
        hwexc_req = 0; mmu_req = 0; hwbrk_req = 0; swbrk_req = 0; irq_req = 0;
        in_dslot = 0; imm_prefix = 0; exc_unit_en = 1; exc_cause = 0;
        mmu_is_miss = 0; mmu_is_fetch = 0; mmu_is_store = 0;
        mmu_addr = 0; cur_pc = 32'h0000_0200; branch_target = 32'h0000_7700;
        msr_in = 32'h0000_0002;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_idle(input string req);
        clear_reqs();
        step();
        chk(req, {31'd0, rdr_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R12 reset valid", {31'd0, rdr_valid}, 0);
        chk("R12 reset pc", rdr_pc, 0);
        chk("R12 reset msr", msr_out, 0);
        chk("R12 reset dbl", {31'd0, dbl_fault}, 0);
    endtask

    task automatic t_hwexc(input logic ds);
        clear_reqs();
        cur_pc = 32'h0000_0100; in_dslot = ds; branch_target = 32'h0000_4440;
        msr_in = (32'd1 << B_IE) | (32'd1 << B_UM) | (32'd1 << B_VM);
        exc_cause = 5'd5; hwexc_req = 1;
        step();
        chk("R1 valid", {31'd0, rdr_valid}, 1);
        chk("R1 pc", rdr_pc, BASE + 32'h20);
        chk("R1 link idx", {27'd0, link_idx}, 17);
        chk("R1 link data", link_data, 32'h0000_0104);
        chk("R1 esr", esr_out, 32'd5 | (32'(ds) << 12));
        chk("R6 msr", msr_out, exp_msr(msr_in, 1, 0));
        chk("R7 flags_clr", {31'd0, flags_clr}, 1);
        chk("R8 btr_we", {31'd0, btr_we}, {31'd0, ds});
        if (ds) chk("R8 btr", btr_out, 32'h0000_4440);
        expect_idle("R12 single-cycle strobe");
    endtask

    task automatic t_mmu();
        for (int i = 0; i < 8; i++) begin
            logic [31:0] code;
            clear_reqs();
            mmu_is_miss = i[0]; mmu_is_fetch = i[1]; mmu_is_store = i[2];
            cur_pc = 32'h0000_0300 + 32'(i * 4); mmu_addr = 32'hC000_0010 + 32'(i);
            msr_in = (32'd1 << B_UMS) | (32'd1 << B_VMS) | (32'd1 << B_IE);
            mmu_req = 1;
            step();
            code = (i[0] ? 32'd18 : 32'd16) + (i[1] ? 32'd1 : 32'd0) + (i[2] ? 32'h400 : 32'h0);
            chk("R2 pc", rdr_pc, BASE + 32'h20);
            chk("R2 link", {link_we, 26'd0, link_idx} , {1'b1, 26'd0, 5'd17});
            chk("R2 link data", link_data, 32'h0000_0300 + 32'(i * 4));
            chk("R2 esr", esr_out, code);
            chk("R2 ear", ear_out, 32'hC000_0010 + 32'(i));
            chk("R6 stale save cleared", msr_out, exp_msr(msr_in, 1, 0));
        end
        expect_idle("R12 idle after mmu");
    endtask

    task automatic t_irq();
        clear_reqs();
        cur_pc = 32'h0000_0440;
        msr_in = (32'd1 << B_IE) | (32'd1 << B_UM);
        irq_req = 1;
        step();
        chk("R3 valid", {31'd0, rdr_valid}, 1);
        chk("R3 pc", rdr_pc, BASE + 32'h10);
        chk("R3 link", {27'd0, link_idx}, 14);
        chk("R3 link data", link_data, 32'h0000_0440);
        chk("R3 msr", msr_out, exp_msr(msr_in, 0, 0));
        chk("R3 esr_we", {31'd0, esr_we}, 0);
        chk("R7 no flags_clr", {31'd0, flags_clr}, 0);
        expect_idle("R12 idle after irq");
    endtask

    task automatic t_irq_blocked();
        for (int k = 0; k < 5; k++) begin
            clear_reqs();
            irq_req = 1;
            msr_in = 32'd1 << B_IE;
            case (k)
                0: msr_in = 0;
                1: msr_in[B_EIP] = 1'b1;
                2: msr_in[B_BIP] = 1'b1;
                3: in_dslot = 1;
                default: imm_prefix = 1;
            endcase
            step();
            chk("R4 irq blocked", {31'd0, rdr_valid}, 0);
        end
    endtask

    task automatic t_breaks();
        clear_reqs();
        cur_pc = 32'h0000_0550; msr_in = (32'd1 << B_VM) | 32'd2;
        hwbrk_req = 1;
        step();
        chk("R5 hwbrk pc", rdr_pc, BASE + 32'h18);
        chk("R5 hwbrk link", {27'd0, link_idx}, 16);
        chk("R5 hwbrk data", link_data, 32'h0000_0550);
        chk("R5 hwbrk msr", msr_out, exp_msr(msr_in, 0, 1));
        clear_reqs();
        branch_target = 32'h0000_9990; swbrk_req = 1;
        step();
        chk("R5 swbrk valid", {31'd0, rdr_valid}, 1);
        chk("R5 swbrk pc", rdr_pc, 32'h0000_9990);
        chk("R5 swbrk no link", {31'd0, link_we}, 0);
        chk("R5 swbrk msr", msr_out, exp_msr(msr_in, 0, 1));
        expect_idle("R12 idle after brk");
    endtask

    task automatic t_priority();
        clear_reqs();
        mmu_req = 1; hwexc_req = 1; hwbrk_req = 1; swbrk_req = 1; irq_req = 1;
        mmu_addr = 32'h1234_0000;
        step();
        chk("R10 mmu first", {31'd0, ear_we}, 1);
        clear_reqs();
        hwexc_req = 1; hwbrk_req = 1; irq_req = 1;
        step();
        chk("R10 hwexc over brk", {27'd0, link_idx}, 17);
        chk("R10 hwexc not mmu", {31'd0, ear_we}, 0);
        clear_reqs();
        hwbrk_req = 1; swbrk_req = 1; irq_req = 1;
        step();
        chk("R10 hwbrk over swbrk", rdr_pc, BASE + 32'h18);
        clear_reqs();
        swbrk_req = 1; irq_req = 1;
        step();
        chk("R10 swbrk over irq", rdr_pc, 32'h0000_7700);
        expect_idle("R12 idle after priority");
    endtask

    task automatic t_exc_disabled();
        clear_reqs();
        exc_unit_en = 0; hwexc_req = 1;
        step();
        chk("R9 ignored", {31'd0, rdr_valid}, 0);
        clear_reqs();
        exc_unit_en = 0; hwexc_req = 1; irq_req = 1;
        step();
        chk("R9 irq taken", rdr_pc, BASE + 32'h10);
        chk("R9 no esr", {31'd0, esr_we}, 0);
    endtask

    task automatic t_double();
        clear_reqs();
        msr_in = (32'd1 << B_EIP); mmu_req = 1;
        step();
        chk("R11 no redirect", {31'd0, rdr_valid}, 0);
        chk("R11 dbl set", {31'd0, dbl_fault}, 1);
        clear_reqs();
        step();
        step();
        chk("R11 dbl sticky", {31'd0, dbl_fault}, 1);
    endtask

    initial begin
        rst_n = 0;
        clear_reqs();
        step();
        step();
        t_reset();
        rst_n = 1;
        step();
        t_hwexc(0);
        t_hwexc(1);
        t_mmu();
        t_irq();
        t_irq_blocked();
        t_breaks();
        t_priority();
        t_exc_disabled();
        t_double();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule